// File: doc/BRIEF.md
# 16-bit Arithmetic Logic Unit

This unit is the combinational datapath core of a small 16-bit load/store processor. It takes two operands and a 4-bit operation code from the instruction decoder. The first operand is always the source register. The second is either another register or an immediate that the decoder has already extended. The unit returns a 16-bit result together with zero, sign and carry indicators. The decoder also uses the add operation to form memory addresses.

The operation code is split into a 2-bit group and a 2-bit function field. Within the arithmetic/logic group and the shift group, the function field keeps the ordering that the instruction encoding uses. This lets the decoder pass those bits straight through.

Two operations differ from the usual convention. Subtract is reversed: it returns the second operand minus the first. The logic operation is AND with the complement of the second operand. Beside these sit:

- rotates and logical shifts that use only four bits of shift amount,
- a bit-reversal operation,
- four set-on-condition operations that return 0 or 1.

Top module: `alu16_core`

## Requirements
- R1: Operation code 0000 (add) gives result = opa + opb modulo 2^16.
- R2: Operation code 0001 (reversed subtract) gives result = opb - opa modulo 2^16.
- R3: Operation code 0010 gives opa XOR opb. Operation code 0011 gives opa AND NOT opb.
- R4: Operation codes 0100, 0101, 0110 and 0111 give, in that order, rotate left, logical shift left, rotate right and logical shift right of opa. The amount is opb[3:0], and opb[15:4] has no effect. Logical shifts fill with zeros.
- R5: A rotate with opb[3:0] = 0 returns opa unchanged.
- R6: Operation code 1100 gives the bit reversal of opa: result[i] = opa[15-i] for every i.
- R7: Operation codes 1000, 1001 and 1010 return 1 when opa equals, is less than, or is less than or equal to opb, and 0 otherwise. Only bit 0 can be set. The ordering is two's-complement signed and is correct when opa - opb overflows.
- R8: Operation code 1011 returns 1 exactly when opa + opb carries out of bit 15, and 0 otherwise.
- R9: zero_flag is 1 exactly when the result is all zeros. sign_flag equals result bit 15.
- R10: For operation codes 0000 and 1011, carry_flag is the carry out of opa + opb. For 0001, carry_flag is 1 when opb - opa needs no borrow, that is when opb >= opa unsigned. For every other code, carry_flag is 0.
- R11: Operation codes 1101, 1110 and 1111 give a result of 0 and carry_flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code: group in bits 3:2, function in bits 1:0 |
| opa | input | 16 | First operand (source register) |
| opb | input | 16 | Second operand (register or pre-extended immediate) |
| result | output | 16 | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| sign_flag | output | 1 | Copy of result bit 15 |
| carry_flag | output | 1 | Carry or no-borrow of the adder for add, reversed subtract and carry-compare |

## Verification
A single adder carry chain drives both the carry-compare result bit and carry_flag in the same evaluation. Each carry-compare vector therefore judges the two outputs together against one hand-computed carry. The signed less-than path and the zero detector also act at once on one subtraction. Vectors such as 0x8000 against 0x0001 and 0x7FFF against 0xFFFF make that subtraction overflow. The bench then expects both the corrected comparison bit and the matching zero and sign flags.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_RSUB = 4'b0001,
        OP_XOR  = 4'b0010,
        OP_ANDN = 4'b0011,
        OP_ROTL = 4'b0100,
        OP_SHL  = 4'b0101,
        OP_ROTR = 4'b0110,
        OP_SHR  = 4'b0111,
        OP_EQ   = 4'b1000,
        OP_LT   = 4'b1001,
        OP_LE   = 4'b1010,
        OP_CO   = 4'b1011,
        OP_REV  = 4'b1100
    } alu_op_e;

    localparam logic [1:0] GRP_ARITH = 2'b00;
    localparam logic [1:0] GRP_SHIFT = 2'b01;
    localparam logic [1:0] GRP_COND  = 2'b10;
    localparam logic [1:0] GRP_MISC  = 2'b11;

endpackage

// File: rtl/alu16_adder.sv
module alu16_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_eff;
    logic [WIDTH:0]   full;

    assign y_eff = sub ? ~y : y;
    assign full  = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, sub};
    assign sum   = full[WIDTH-1:0];
    assign cout  = full[WIDTH];
    // signed overflow: same-sign inputs, different-sign sum
    assign ovf   = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]         din,
    input  logic [$clog2(WIDTH)-1:0] amt,
    input  logic                     to_right,
    input  logic                     rotate,
    output logic [WIDTH-1:0]         dout
);
    localparam int SHW = $clog2(WIDTH);

    logic [SHW:0][WIDTH-1:0] stage;

    assign stage[0] = din;

    // one barrel stage per amount bit, stage s moves by 2**s places
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [WIDTH-1:0] cur;
        logic [WIDTH-1:0] moved;
        assign cur = stage[s];
        always_comb begin
            if (to_right) begin
                moved = rotate ? {cur[K-1:0], cur[WIDTH-1:K]}
                               : {{K{1'b0}}, cur[WIDTH-1:K]};
            end else begin
                moved = rotate ? {cur[WIDTH-1-K:0], cur[WIDTH-1:WIDTH-K]}
                               : {cur[WIDTH-1-K:0], {K{1'b0}}};
            end
        end
        assign stage[s+1] = amt[s] ? moved : cur;
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] x_xor,
    output logic [WIDTH-1:0] x_andn,
    output logic [WIDTH-1:0] x_rev
);
    assign x_xor  = a ^ b;
    assign x_andn = a & ~b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign x_rev[i] = a[WIDTH-1-i];
    end

endmodule

// File: rtl/alu16_cond.sv
module alu16_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] diff,
    input  logic             ovf,
    input  logic             cout,
    input  logic [1:0]       fn,
    output logic             hit
);
    logic is_eq;
    logic is_lt;

    assign is_eq = (diff == '0);
    // signed less-than corrected for overflow of the subtraction
    assign is_lt = diff[WIDTH-1] ^ ovf;

    always_comb begin
        unique case (fn)
            2'b00:   hit = is_eq;
            2'b01:   hit = is_lt;
            2'b10:   hit = is_lt | is_eq;
            default: hit = cout;
        endcase
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             sign_flag,
    output logic             carry_flag
);
    localparam int SHW = $clog2(WIDTH);

    logic [1:0] grp;
    logic [1:0] fn;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_sub;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;

    logic [WIDTH-1:0] sh_out;
    logic [WIDTH-1:0] b_xor;
    logic [WIDTH-1:0] b_andn;
    logic [WIDTH-1:0] b_rev;
    logic             cond_hit;

    assign grp = op_sel[3:2];
    assign fn  = op_sel[1:0];

    // adder operand steering: reversed subtract swaps, compares take a - b
    always_comb begin
        add_x   = opa;
        add_y   = opb;
        add_sub = 1'b0;
        if (op_sel == OP_RSUB) begin
            add_x   = opb;
            add_y   = opa;
            add_sub = 1'b1;
        end else if (op_sel == OP_EQ || op_sel == OP_LT || op_sel == OP_LE) begin
            add_sub = 1'b1;
        end
    end

    alu16_adder #(.WIDTH(WIDTH)) u_adder (
        .x    (add_x),
        .y    (add_y),
        .sub  (add_sub),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu16_shifter #(.WIDTH(WIDTH)) u_shifter (
        .din      (opa),
        .amt      (opb[SHW-1:0]),
        .to_right (fn[1]),
        .rotate   (~fn[0]),
        .dout     (sh_out)
    );

    alu16_bitops #(.WIDTH(WIDTH)) u_bitops (
        .a      (opa),
        .b      (opb),
        .x_xor  (b_xor),
        .x_andn (b_andn),
        .x_rev  (b_rev)
    );

    alu16_cond #(.WIDTH(WIDTH)) u_cond (
        .diff (add_sum),
        .ovf  (add_ovf),
        .cout (add_cout),
        .fn   (fn),
        .hit  (cond_hit)
    );

    always_comb begin
        result = '0;
        unique case (grp)
            GRP_ARITH: begin
                unique case (fn)
                    2'b00, 2'b01: result = add_sum;
                    2'b10:        result = b_xor;
                    default:      result = b_andn;
                endcase
            end
            GRP_SHIFT: result = sh_out;
            GRP_COND:  result = {{(WIDTH-1){1'b0}}, cond_hit};
            default:   result = (fn == 2'b00) ? b_rev : '0;
        endcase
    end

    assign zero_flag  = (result == '0);
    assign sign_flag  = result[WIDTH-1];
    assign carry_flag = (op_sel == OP_ADD || op_sel == OP_RSUB || op_sel == OP_CO)
                        ? add_cout : 1'b0;

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag,
    input logic             sign_flag,
    input logic             carry_flag
);
    localparam int SHW = $clog2(WIDTH);

    always_comb begin
        p_zero_flag_r9: assert (zero_flag == (result == '0));
        p_sign_flag_r9: assert (sign_flag == result[WIDTH-1]);
        if (op_sel == OP_RSUB) begin
            p_rsub_sum_r2: assert (result + opa == opb);
        end
        if (op_sel[3:2] == GRP_COND) begin
            p_bool_only_r7: assert (result[WIDTH-1:1] == '0);
        end
        if (op_sel == OP_CO) begin
            p_carry_bit_r8: assert (result[0] == carry_flag);
        end
        if ((op_sel == OP_ROTL || op_sel == OP_ROTR) && opb[SHW-1:0] == '0) begin
            p_rot_zero_r5: assert (result == opa);
        end
        if (op_sel == OP_REV) begin
            p_rev_ends_r6: assert (result[0] == opa[WIDTH-1] && result[WIDTH-1] == opa[0]);
        end
        if (op_sel != OP_ADD && op_sel != OP_RSUB && op_sel != OP_CO) begin
            p_carry_quiet_r10: assert (!carry_flag);
        end
        if (op_sel > OP_REV) begin
            p_unused_zero_r11: assert (result == '0);
        end
    end

endmodule

bind alu16_core alu16_core_chk #(.WIDTH(WIDTH)) u_chk (
    .op_sel     (op_sel),
    .opa        (opa),
    .opb        (opb),
    .result     (result),
    .zero_flag  (zero_flag),
    .sign_flag  (sign_flag),
    .carry_flag (carry_flag)
);

// File: tb/test_alu16_core.sv
module test_alu16_core;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 25;

    // {req[58:55], op[54:51], a[50:35], b[34:19], y[18:3], z, n, c}
    localparam logic [58:0] VECS [NV] = '{
        {4'd1,  4'h0, 16'h0001, 16'h0002, 16'h0003, 3'b000}, // R1
        {4'd1,  4'h0, 16'hFFFF, 16'h0001, 16'h0000, 3'b101}, // R1 wrap with carry
        {4'd2,  4'h1, 16'h0003, 16'h0005, 16'h0002, 3'b001}, // R2 no borrow
        {4'd2,  4'h1, 16'h0005, 16'h0003, 16'hFFFE, 3'b010}, // R2 borrow
        {4'd3,  4'h2, 16'hF0F0, 16'hFF00, 16'h0FF0, 3'b000}, // R3 xor
        {4'd3,  4'h3, 16'hF0F0, 16'hFF00, 16'h00F0, 3'b000}, // R3 andn
        {4'd4,  4'h4, 16'h8001, 16'h0001, 16'h0003, 3'b000}, // R4 rotl
        {4'd4,  4'h4, 16'h1234, 16'h0014, 16'h2341, 3'b000}, // R4 upper amount bits ignored
        {4'd4,  4'h5, 16'h8001, 16'h0004, 16'h0010, 3'b000}, // R4 shl
        {4'd4,  4'h6, 16'h0001, 16'h0001, 16'h8000, 3'b010}, // R4 rotr
        {4'd4,  4'h7, 16'h8000, 16'h000F, 16'h0001, 3'b000}, // R4 shr
        {4'd5,  4'h4, 16'hABCD, 16'h0000, 16'hABCD, 3'b010}, // R5
        {4'd5,  4'h6, 16'hABCD, 16'h0010, 16'hABCD, 3'b010}, // R5
        {4'd6,  4'hC, 16'h0001, 16'h0000, 16'h8000, 3'b010}, // R6
        {4'd6,  4'hC, 16'h1234, 16'hFFFF, 16'h2C48, 3'b000}, // R6
        {4'd7,  4'h8, 16'h0005, 16'h0005, 16'h0001, 3'b000}, // R7 eq
        {4'd7,  4'h8, 16'h0005, 16'h0006, 16'h0000, 3'b100}, // R7 ne
        {4'd7,  4'h9, 16'h8000, 16'h0001, 16'h0001, 3'b000}, // R7 lt with overflow
        {4'd7,  4'h9, 16'h7FFF, 16'hFFFF, 16'h0000, 3'b100}, // R7 not lt with overflow
        {4'd7,  4'hA, 16'hFFFF, 16'hFFFF, 16'h0001, 3'b000}, // R7 le equal
        {4'd7,  4'hA, 16'h0002, 16'h0001, 16'h0000, 3'b100}, // R7 not le
        {4'd8,  4'hB, 16'h8000, 16'h8000, 16'h0001, 3'b001}, // R8 carry
        {4'd8,  4'hB, 16'h7FFF, 16'h0001, 16'h0000, 3'b100}, // R8 no carry
        {4'd11, 4'hD, 16'h1234, 16'h5678, 16'h0000, 3'b100}, // R11
        {4'd11, 4'hF, 16'hFFFF, 16'hFFFF, 16'h0000, 3'b100}  // R11
    };

    logic        clk = 1'b0;
    logic [3:0]  op_sel = 4'h0;
    logic [15:0] opa = 16'h0000;
    logic [15:0] opb = 16'h0000;
    logic [15:0] result;
    logic        zero_flag;
    logic        sign_flag;
    logic        carry_flag;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_core i_alu16_core (
        .op_sel     (op_sel),
        .opa        (opa),
        .opb        (opb),
        .result     (result),
        .zero_flag  (zero_flag),
        .sign_flag  (sign_flag),
        .carry_flag (carry_flag)
    );

    task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_sel = op;
        opa    = a;
        opb    = b;
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] y,
                         input logic z, input logic n, input logic c);
        n_checks++;
        if (result !== y || zero_flag !== z || sign_flag !== n || carry_flag !== c) begin
            n_fails++;
            $display("FAIL %s op=%h a=%h b=%h: got y=%h z=%b n=%b c=%b, expected y=%h z=%b n=%b c=%b",
                     req, op_sel, opa, opb, result, zero_flag, sign_flag, carry_flag, y, z, n, c);
        end
    endtask

    initial begin
        // idle inputs: add of zeros (R9 zero flag, R1)
        apply(4'h0, 16'h0000, 16'h0000);
        check("R9", 16'h0000, 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [58:0] v;
            v = VECS[i];
            apply(v[54:51], v[50:35], v[34:19]);
            check($sformatf("R%0d", v[58:55]), v[18:3], v[2], v[1], v[0]);
        end

        // R10: equal operands on reversed subtract need no borrow
        apply(4'h1, 16'h4321, 16'h4321);
        check("R10", 16'h0000, 1'b1, 1'b0, 1'b1);
        // R10: add overflow to zero keeps carry
        apply(4'h0, 16'h8000, 16'h8000);
        check("R10", 16'h0000, 1'b1, 1'b0, 1'b1);
        // R4: high amount bits ignored on logical shift
        apply(4'h5, 16'hFFFF, 16'hFFF0);
        check("R4", 16'hFFFF, 1'b0, 1'b1, 1'b0);

        // R4: every rotate-left amount of a single bit
        for (int k = 0; k < 16; k++) begin
            logic [15:0] e;
            e = 16'h0001 << k;
            apply(4'h4, 16'h0001, 16'(k));
            check("R4", e, 1'b0, e[15], 1'b0);
        end
        // R6: reversal moves each single bit to its mirror
        for (int k = 0; k < 16; k++) begin
            logic [15:0] e;
            e = 16'h0001 << (15 - k);
            apply(4'hC, 16'h0001 << k, 16'h0000);
            check("R6", e, 1'b0, e[15], 1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule